// File: doc/BRIEF.md
# Dual-Profile Power Domain Manager

This block manages power for a low-power sensing chip that has many switchable power domains. It holds two programmable domain-configuration profiles. The awake profile applies while the processor runs. The asleep profile applies while the processor is powered down and the chip only collects data. A small state machine chooses which profile drives the memory-bank controls, and it changes state on its own. When the processor reports that its task has finished, the block powers the processor down. When an interrupt is waiting for the processor, the block brings it back up.

Software loads either profile through a simple address/data/write-enable port. Each profile word packs one 2-bit state per memory bank. The outputs give, for every bank, a power enable and a retention enable. They also include the processor power enable and the peripheral-domain enable, which is never deasserted. The transitions are sequenced so the processor never runs while its memories are in the asleep configuration. On the way up, the banks are restored one cycle before the processor is powered. On the way down, the processor is cut off one cycle before the banks change.

Top module: `pwr_profile_mgr`

## Requirements
- R1: Reset leaves the manager awake, with the processor powered. Both profiles reset to every bank on, so all bank power enables are 1 and all retention enables are 0.
- R2: Bank i is held in bits [2i+1:2i] of a profile word. Code 00 gives power 0 and retention 0 (off). Code 01 gives power 0 and retention 1 (retention). Codes 10 and 11 both give power 1 and retention 0 (on).
- R3: A write with cfg_addr 0 loads the awake profile and a write with cfg_addr 1 loads the asleep profile. If the written profile is the one in use, the bank outputs show the new value in the cycle after the write edge.
- R4: A write to the profile that is not in use leaves the bank outputs unchanged.
- R5: If task_done is high without irq_pending while awake, the processor power enable drops one cycle after that edge while the banks keep the awake profile. One cycle later the banks take the asleep profile.
- R6: If irq_pending is high while asleep, the banks take the awake profile one cycle after that edge while the processor stays off. The processor power enable rises one cycle after that.
- R7: If task_done and irq_pending are both high while awake, the manager stays awake.
- R8: The peripheral-domain enable is 1 in every state.
- R9: task_done has no effect unless the manager is fully awake. irq_pending has no effect during the cycle in which the processor has just been powered down, and the sequence still reaches the asleep state.
- R10: The processor power enable stays 0 for as long as the manager is asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Profile write enable |
| cfg_addr | input | 1 | Profile select: 0 awake, 1 asleep |
| cfg_wdata | input | 26 | Profile word, 2 bits per bank |
| task_done | input | 1 | Processor reports its task is finished |
| irq_pending | input | 1 | An interrupt is waiting for the processor |
| bank_pwr_en | output | 13 | Per-bank power enable |
| bank_ret_en | output | 13 | Per-bank retention enable |
| cpu_pwr_en | output | 1 | Processor domain power enable |
| periph_pwr_en | output | 1 | Peripheral domain enable |

## Verification
Every result comes from a register, so a profile write or a control input shows up on the outputs in the cycle after the edge that samples it. Both halves of a sequenced change are due one cycle apart: one cycle and two cycles after the task-done or interrupt edge. The driver tags each expected snapshot with the cycle count at which it becomes due. The monitor compares only at the falling edge of that cycle, which keeps each check away from the edge where the outputs change.

// File: rtl/pwr_mgr_pkg.sv
package pwr_mgr_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE       = 2'd0,
        ST_SLEEP_ENTRY = 2'd1,
        ST_ASLEEP      = 2'd2,
        ST_WAKE_ENTRY  = 2'd3
    } pm_state_e;

    localparam int unsigned BANK_CODE_W = 2;
    localparam logic [BANK_CODE_W-1:0] BANK_OFF = 2'b00;
    localparam logic [BANK_CODE_W-1:0] BANK_RET = 2'b01;
    localparam logic [BANK_CODE_W-1:0] BANK_ON  = 2'b10;

endpackage

// File: rtl/pwr_profile_regs.sv
module pwr_profile_regs
    import pwr_mgr_pkg::*;
#(
    parameter int unsigned NBANK = 13,
    localparam int unsigned PW = NBANK * BANK_CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          addr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] awake_prof,
    output logic [PW-1:0] sleep_prof
);

    typedef struct packed {
        logic [PW-1:0] awake;
        logic [PW-1:0] sleep;
    } prof_t;

    localparam logic [PW-1:0] ALL_ON = {NBANK{BANK_ON}};

    prof_t prof_d, prof_q;

    always_comb begin
        prof_d = prof_q;
        if (we) begin
            if (addr) prof_d.sleep = wdata;
            else      prof_d.awake = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prof_q <= '{awake: ALL_ON, sleep: ALL_ON};
        else        prof_q <= prof_d;
    end

    assign awake_prof = prof_q.awake;
    assign sleep_prof = prof_q.sleep;

    // R3
    awake_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !addr) |=> (awake_prof == $past(wdata)));

    // R3
    sleep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr) |=> (sleep_prof == $past(wdata)));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_mgr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic task_done,
    input  logic irq_pending,
    output logic cpu_on,
    output logic use_awake
);

    typedef struct packed {
        pm_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_AWAKE:       if (task_done && !irq_pending) seq_d.st = ST_SLEEP_ENTRY;
            ST_SLEEP_ENTRY: seq_d.st = ST_ASLEEP;
            ST_ASLEEP:      if (irq_pending) seq_d.st = ST_WAKE_ENTRY;
            ST_WAKE_ENTRY:  seq_d.st = ST_AWAKE;
            default:        seq_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_AWAKE};
        else        seq_q <= seq_d;
    end

    assign cpu_on    = (seq_q.st == ST_AWAKE);
    assign use_awake = (seq_q.st != ST_ASLEEP);

    // R5
    cpu_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_on && task_done && !irq_pending) |=> (!cpu_on && use_awake));

    // R5
    banks_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_on) |=> !use_awake);

    // R6
    banks_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_on) |-> ($past(use_awake) && !$past(cpu_on)));

    // R7
    stay_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_on && task_done && irq_pending) |=> cpu_on);

    // R10
    asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_awake && !irq_pending) |=> (!use_awake && !cpu_on));

endmodule

// File: rtl/pwr_bank_decode.sv
module pwr_bank_decode
    import pwr_mgr_pkg::*;
#(
    parameter int unsigned NBANK = 13,
    localparam int unsigned PW = NBANK * BANK_CODE_W
) (
    input  logic             sel_awake,
    input  logic [PW-1:0]    awake_prof,
    input  logic [PW-1:0]    sleep_prof,
    output logic [NBANK-1:0] pwr_en,
    output logic [NBANK-1:0] ret_en
);

    logic [PW-1:0] active;
    assign active = sel_awake ? awake_prof : sleep_prof;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [BANK_CODE_W-1:0] code;
        assign code      = active[b*BANK_CODE_W +: BANK_CODE_W];
        assign pwr_en[b] = code[1];
        assign ret_en[b] = (code == BANK_RET);
    end

endmodule

// File: rtl/pwr_profile_mgr.sv
module pwr_profile_mgr
    import pwr_mgr_pkg::*;
#(
    parameter int unsigned NBANK = 13,
    localparam int unsigned PW = NBANK * BANK_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [PW-1:0]    cfg_wdata,
    input  logic             task_done,
    input  logic             irq_pending,
    output logic [NBANK-1:0] bank_pwr_en,
    output logic [NBANK-1:0] bank_ret_en,
    output logic             cpu_pwr_en,
    output logic             periph_pwr_en
);

    logic [PW-1:0] awake_prof;
    logic [PW-1:0] sleep_prof;
    logic          use_awake;

    pwr_profile_regs #(.NBANK(NBANK)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .awake_prof (awake_prof),
        .sleep_prof (sleep_prof)
    );

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .task_done   (task_done),
        .irq_pending (irq_pending),
        .cpu_on      (cpu_pwr_en),
        .use_awake   (use_awake)
    );

    pwr_bank_decode #(.NBANK(NBANK)) u_dec (
        .sel_awake  (use_awake),
        .awake_prof (awake_prof),
        .sleep_prof (sleep_prof),
        .pwr_en     (bank_pwr_en),
        .ret_en     (bank_ret_en)
    );

    assign periph_pwr_en = 1'b1;

    // R4
    inactive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr == use_awake) && !task_done && !irq_pending && cpu_pwr_en)
        |=> ($stable(bank_pwr_en) && $stable(bank_ret_en)));

endmodule

// File: tb/pwr_profile_mgr_tb.sv
`timescale 1ns/1ps
module pwr_profile_mgr_tb;

    localparam int NB = 13;
    localparam int PW = 2 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [PW-1:0] cfg_wdata = '0;
    logic          task_done = 1'b0;
    logic          irq_pending = 1'b0;
    logic [NB-1:0] bank_pwr_en;
    logic [NB-1:0] bank_ret_en;
    logic          cpu_pwr_en;
    logic          periph_pwr_en;

    always #2.5 clk = ~clk;

    pwr_profile_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .task_done(task_done), .irq_pending(irq_pending),
        .bank_pwr_en(bank_pwr_en), .bank_ret_en(bank_ret_en),
        .cpu_pwr_en(cpu_pwr_en), .periph_pwr_en(periph_pwr_en)
    );

    typedef struct {
        int            due;
        logic          cpu;
        logic [NB-1:0] pwr;
        logic [NB-1:0] ret;
        string         tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int            m_state = 0;
    logic [PW-1:0] m_awake = {NB{2'b10}};
    logic [PW-1:0] m_sleep = {NB{2'b10}};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NB-1:0] exp_pwr(input logic [PW-1:0] p);
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) r[i] = p[2*i+1];
        return r;
    endfunction

    function automatic logic [NB-1:0] exp_ret(input logic [PW-1:0] p);
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) r[i] = (p[2*i+1 -: 2] == 2'b01);
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each expected snapshot in its due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " cpu"}, 64'(cpu_pwr_en), 64'(e.cpu));
            check({e.tag, " banks"}, {38'd0, bank_pwr_en, bank_ret_en}, {38'd0, e.pwr, e.ret});
            check({e.tag, " R8 periph"}, 64'(periph_pwr_en), 64'd1);
        end
    end

    // driver: applies one cycle of stimulus and predicts the outputs that follow
    task automatic step(input logic td, input logic irq, input logic we,
                        input logic adr, input logic [PW-1:0] dat, input string tag);
        exp_t e;
        logic [PW-1:0] p;
        @(posedge clk);
        #1;
        task_done = td; irq_pending = irq; cfg_we = we; cfg_addr = adr; cfg_wdata = dat;
        if (we) begin
            if (adr) m_sleep = dat;
            else     m_awake = dat;
        end
        case (m_state)
            0: if (td && !irq) m_state = 1;
            1: m_state = 2;
            2: if (irq) m_state = 3;
            default: m_state = 0;
        endcase
        p = (m_state == 2) ? m_sleep : m_awake;
        e.due = cyc + 1;
        e.cpu = (m_state == 0);
        e.pwr = exp_pwr(p);
        e.ret = exp_ret(p);
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        logic [PW-1:0] pa, pb, pc, pd;
        for (int i = 0; i < NB; i++) begin
            pa[2*i +: 2] = 2'(i % 4);
            pb[2*i +: 2] = 2'((i + 1) % 4);
        end
        pc = '0;
        pd = {NB{2'b01}};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset cpu", 64'(cpu_pwr_en), 64'd1);
        check("R1 reset banks", {38'd0, bank_pwr_en, bank_ret_en}, {38'd0, {NB{1'b1}}, {NB{1'b0}}});
        check("R8 reset periph", 64'(periph_pwr_en), 64'd1);

        step(0, 0, 1, 0, pa, "R3 R2 awake write");
        step(0, 0, 1, 1, pb, "R4 asleep write while awake");
        step(1, 1, 0, 0, '0, "R7 both high");
        step(0, 0, 0, 0, '0, "R7 hold");
        step(1, 0, 0, 0, '0, "R5 sleep entry");
        step(0, 1, 0, 0, '0, "R9 irq in entry");
        step(0, 0, 0, 0, '0, "R5 R10 asleep");
        step(1, 0, 0, 0, '0, "R9 td asleep");
        step(0, 0, 1, 1, pc, "R3 asleep write while asleep");
        step(0, 0, 1, 0, pd, "R4 awake write while asleep");
        step(0, 1, 0, 0, '0, "R6 wake entry");
        step(1, 0, 0, 0, '0, "R9 R6 td in wake entry");
        step(0, 0, 0, 0, '0, "R6 awake");
        step(1, 0, 1, 1, pb, "R5 sleep with write");
        step(0, 0, 0, 0, '0, "R5 asleep B");
        step(0, 1, 0, 0, '0, "R6 wake again");
        step(0, 0, 0, 0, '0, "R6 awake again");
        step(0, 0, 0, 0, '0, "R1 idle");
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule